// File: doc/BRIEF.md
# Latched Program Counter Unit

This block holds the program counter of a processor whose instructions are 16 bits wide and whose program memory is addressed in bytes. The counter is 21 bits wide and always word-aligned, so it moves forward by two on every sequential advance. A direct-load port lets jumps, calls and branches place a complete new address into the counter in one cycle.

Software reaches the counter through a small register port. Only the low byte of the counter can be read or written there. The middle byte and the top five bits are set through two shadow latches. Writing the low byte moves both latches into the counter together with the new low byte, in one cycle. Reading the low byte does the reverse: it copies the live middle and top fields of the counter into the latches. Software can then add an offset to a table base and jump with a single low-byte write.

The register port, the advance strobe and the direct load are plain per-cycle controls with no handshake. The counter has no back-pressure path: each request is acted on in the cycle it is presented. Read data is combinational from the current state.

Top module: `latched_pc_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, the counter and both latches hold zero until the first operation.
- R2: Bit 0 of `pc_o` is always 0. Bit 0 of a low-byte write value and bit 0 of a direct-load address are discarded.
- R3: When `adv_i` is high and no direct load or low-byte write is taken, `pc_o` increases by 2 at the next edge, modulo 2^21 (0x1FFFFE advances to 0).
- R4: Register select codes: 0 is the counter low byte, 1 is the middle latch (8 bits), 2 is the top latch (5 bits, `reg_rdata_o` bits 7:5 read 0, only write bits 4:0 are kept), and 3 reads 0 and ignores writes. `reg_rdata_o` shows the selected item combinationally in the same cycle.
- R5: A write with select 0 sets the counter to {top latch, middle latch, write data with bit 0 cleared} at the next edge.
- R6: A read with select 0 (and no write in the same cycle) copies `pc_o` bits 15:8 into the middle latch and bits 20:16 into the top latch at the next edge.
- R7: A direct load (`load_i` high) sets the counter to `load_addr_i` with bit 0 cleared at the next edge and does not change either latch.
- R8: Priority on the counter: direct load first, then a low-byte write, then a sequential advance. A suppressed advance is dropped, not deferred.
- R9: When `reg_wr_i` and `reg_rd_i` are both high, only the write is performed. A low-byte read side effect does not happen in that cycle.
- R10: Writes with select 1 or 2 change only the addressed latch and never change `pc_o` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Sequential advance strobe |
| load_i | input | 1 | Direct load request (jump, call, branch) |
| load_addr_i | input | 21 | Address for the direct load |
| reg_wr_i | input | 1 | Register port write strobe |
| reg_rd_i | input | 1 | Register port read strobe |
| reg_sel_i | input | 2 | Register select (see R4) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| pc_o | output | 21 | Current program counter |

## Verification
`reg_rdata_o` is due in the same cycle as the select that drives it, so the bench samples it a short delay after driving inputs and before the next rising edge. Every change to the counter or to the latches is due one edge after the request. The bench updates its reference model at that edge and compares `pc_o` at the following falling edge, before it drives the next operation. Latch contents are observed only through read-back on select 1 and 2, which again is checked in the same cycle.

// File: rtl/pclu_pkg.sv
package pclu_pkg;
  localparam int PCLU_PC_W   = 21;
  localparam int PCLU_BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_LOW   = 2'd0,
    SEL_MID   = 2'd1,
    SEL_TOP   = 2'd2,
    SEL_NONE  = 2'd3
  } pclu_sel_e;
endpackage

// File: rtl/pclu_port_decode.sv
module pclu_port_decode
  import pclu_pkg::*;
#(
  parameter int BYTE_W = PCLU_BYTE_W,
  parameter int TOP_W  = 5
) (
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [BYTE_W-1:0] pc_low,
  input  logic [BYTE_W-1:0] mid_q,
  input  logic [TOP_W-1:0]  top_q,
  output logic              wr_low,
  output logic              wr_mid,
  output logic              wr_top,
  output logic              rd_low,
  output logic [BYTE_W-1:0] rdata
);
  pclu_sel_e sel;
  assign sel = pclu_sel_e'(reg_sel);

  // A write takes the port; a read in the same cycle has no side effect.
  assign wr_low = reg_wr && (sel == SEL_LOW);
  assign wr_mid = reg_wr && (sel == SEL_MID);
  assign wr_top = reg_wr && (sel == SEL_TOP);
  assign rd_low = reg_rd && !reg_wr && (sel == SEL_LOW);

  always_comb begin
    unique case (sel)
      SEL_LOW: rdata = pc_low;
      SEL_MID: rdata = mid_q;
      SEL_TOP: rdata = {{(BYTE_W-TOP_W){1'b0}}, top_q};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pclu_latch_bank.sv
module pclu_latch_bank
  import pclu_pkg::*;
#(
  parameter int BYTE_W = PCLU_BYTE_W,
  parameter int TOP_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mid,
  input  logic              wr_top,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              capture,
  input  logic [BYTE_W-1:0] cap_mid,
  input  logic [TOP_W-1:0]  cap_top,
  output logic [BYTE_W-1:0] mid_q,
  output logic [TOP_W-1:0]  top_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_q <= '0;
      top_q <= '0;
    end else if (capture) begin
      mid_q <= cap_mid;
      top_q <= cap_top;
    end else begin
      if (wr_mid) mid_q <= wdata;
      if (wr_top) top_q <= wdata[TOP_W-1:0];
    end
  end
endmodule

// File: rtl/pclu_counter.sv
module pclu_counter
  import pclu_pkg::*;
#(
  parameter int PC_W   = PCLU_PC_W,
  parameter int BYTE_W = PCLU_BYTE_W,
  parameter int TOP_W  = PC_W - 2*BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              load,
  input  logic [PC_W-1:0]   load_addr,
  input  logic              wr_low,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] mid_q,
  input  logic [TOP_W-1:0]  top_q,
  output logic [PC_W-1:0]   pc_q
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic [PC_W-1:0] pc_d;

  always_comb begin
    pc_d = pc_q;
    if (load)
      pc_d = {load_addr[PC_W-1:1], 1'b0};
    else if (wr_low)
      pc_d = {top_q, mid_q, wdata[BYTE_W-1:1], 1'b0};
    else if (adv)
      pc_d = pc_q + STEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/latched_pc_unit.sv
module latched_pc_unit
  import pclu_pkg::*;
#(
  parameter int PC_W   = PCLU_PC_W,
  parameter int BYTE_W = PCLU_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              load_i,
  input  logic [PC_W-1:0]   load_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam int TOP_W = PC_W - 2*BYTE_W;

  logic              wr_low, wr_mid, wr_top, rd_low;
  logic [BYTE_W-1:0] mid_q;
  logic [TOP_W-1:0]  top_q;
  logic [PC_W-1:0]   pc_q;

  pclu_port_decode #(.BYTE_W(BYTE_W), .TOP_W(TOP_W)) u_decode (
    .reg_wr (reg_wr_i),
    .reg_rd (reg_rd_i),
    .reg_sel(reg_sel_i),
    .pc_low (pc_q[BYTE_W-1:0]),
    .mid_q  (mid_q),
    .top_q  (top_q),
    .wr_low (wr_low),
    .wr_mid (wr_mid),
    .wr_top (wr_top),
    .rd_low (rd_low),
    .rdata  (reg_rdata_o)
  );

  pclu_latch_bank #(.BYTE_W(BYTE_W), .TOP_W(TOP_W)) u_latches (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_mid (wr_mid),
    .wr_top (wr_top),
    .wdata  (reg_wdata_i),
    .capture(rd_low),
    .cap_mid(pc_q[2*BYTE_W-1:BYTE_W]),
    .cap_top(pc_q[PC_W-1:2*BYTE_W]),
    .mid_q  (mid_q),
    .top_q  (top_q)
  );

  pclu_counter #(.PC_W(PC_W), .BYTE_W(BYTE_W), .TOP_W(TOP_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv_i),
    .load     (load_i),
    .load_addr(load_addr_i),
    .wr_low   (wr_low),
    .wdata    (reg_wdata_i),
    .mid_q    (mid_q),
    .top_q    (top_q),
    .pc_q     (pc_q)
  );

  assign pc_o = pc_q;
endmodule

// File: rtl/pclu_checker.sv
module pclu_checker #(
  parameter int PC_W   = 21,
  parameter int BYTE_W = 8,
  parameter int TOP_W  = PC_W - 2*BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv_i,
  input logic              load_i,
  input logic [PC_W-1:0]   load_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [1:0]        reg_sel_i,
  input logic [BYTE_W-1:0] reg_wdata_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [BYTE_W-1:0] mid_q,
  input logic [TOP_W-1:0]  top_q
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  // R2
  pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[0] == 1'b0);

  // R3
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && !(reg_wr_i && reg_sel_i == 2'd0))
    |=> pc_o == $past(pc_o) + STEP);

  // R5
  low_write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && reg_wr_i && reg_sel_i == 2'd0)
    |=> pc_o == {$past(top_q), $past(mid_q), $past(reg_wdata_i[BYTE_W-1:1]), 1'b0});

  // R6
  low_read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && !reg_wr_i && reg_sel_i == 2'd0)
    |=> (mid_q == $past(pc_o[2*BYTE_W-1:BYTE_W])) && (top_q == $past(pc_o[PC_W-1:2*BYTE_W])));

  // R7
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> pc_o == {$past(load_addr_i[PC_W-1:1]), 1'b0});

  // R7
  load_keeps_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !reg_wr_i && !reg_rd_i) |=> $stable(mid_q) && $stable(top_q));

  // R10
  latch_write_no_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i && reg_wr_i && reg_sel_i != 2'd0) |=> $stable(pc_o));
endmodule

bind latched_pc_unit pclu_checker #(.PC_W(PC_W), .BYTE_W(BYTE_W)) u_pclu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .adv_i      (adv_i),
  .load_i     (load_i),
  .load_addr_i(load_addr_i),
  .reg_wr_i   (reg_wr_i),
  .reg_rd_i   (reg_rd_i),
  .reg_sel_i  (reg_sel_i),
  .reg_wdata_i(reg_wdata_i),
  .pc_o       (pc_o),
  .mid_q      (mid_q),
  .top_q      (top_q)
);

// File: tb/test_latched_pc_unit.sv
`timescale 1ns/1ps
module test_latched_pc_unit;
  localparam int PC_W = 21;
  localparam int BW   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          adv = 0, load = 0, wr = 0, rd = 0;
  logic [PC_W-1:0] addr = '0;
  logic [1:0]    sel = '0;
  logic [BW-1:0] wdata = '0;
  logic [BW-1:0] rdata;
  logic [PC_W-1:0] pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [PC_W-1:0] m_pc;
  logic [7:0]      m_mid;
  logic [4:0]      m_top;

  always #2 clk = ~clk;

  latched_pc_unit i_latched_pc_unit (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .load_i(load), .load_addr_i(addr),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pc_o(pc)
  );

  function automatic logic [7:0] exp_rdata(logic [1:0] s);
    case (s)
      2'd0:    return m_pc[7:0];
      2'd1:    return m_mid;
      2'd2:    return {3'b000, m_top};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [PC_W-1:0] exp_pc(logic a, logic l, logic [PC_W-1:0] la,
                                             logic w, logic [1:0] s, logic [7:0] d);
    if (l)                 return {la[PC_W-1:1], 1'b0};
    if (w && s == 2'd0)    return {m_top, m_mid, d[7:1], 1'b0};
    if (a)                 return m_pc + 21'd2;
    return m_pc;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One operation: drive at falling edge, check read data in-cycle,
  // update model at the rising edge, check pc at the next falling edge.
  task automatic op(string req, logic a, logic l, logic [PC_W-1:0] la,
                    logic w, logic r, logic [1:0] s, logic [7:0] d);
    logic [PC_W-1:0] npc;
    adv = a; load = l; addr = la; wr = w; rd = r; sel = s; wdata = d;
    #1;
    check("R4 rdata", rdata, exp_rdata(s));
    npc = exp_pc(a, l, la, w, s, d);
    @(posedge clk);
    if (r && !w && s == 2'd0) begin m_mid = m_pc[15:8]; m_top = m_pc[20:16]; end
    if (w && s == 2'd1) m_mid = d;
    if (w && s == 2'd2) m_top = d[4:0];
    m_pc = npc;
    @(negedge clk);
    adv = 0; load = 0; wr = 0; rd = 0;
    check(req, pc, m_pc);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_pc = '0; m_mid = '0; m_top = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pc in reset", pc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pc after reset", pc, 0);
    sel = 2'd1; #1; check("R1 mid latch", rdata, 0);
    sel = 2'd2; #1; check("R1 top latch", rdata, 0);
    @(negedge clk);

    // R10 latch writes leave pc; R4 top latch masking
    op("R10 mid write", 0, 0, 0, 1, 0, 2'd1, 8'hFF);
    op("R10 top write", 0, 0, 0, 1, 0, 2'd2, 8'hFF);
    op("R4 top reads 5 bits", 0, 0, 0, 0, 0, 2'd2, 8'h00);
    op("R4 sel3 write ignored", 0, 0, 0, 1, 0, 2'd3, 8'hAA);
    // R5 + R2: odd low write, full commit
    op("R5 R2 low write odd", 0, 0, 0, 1, 0, 2'd0, 8'hFF);
    check("R5 pc top", pc, 21'h1FFFFE);
    // R3 wrap
    op("R3 wrap", 1, 0, 0, 0, 0, 2'd0, 0);
    check("R3 wrap to zero", pc, 0);
    // R7 odd direct load; latches untouched
    op("R7 R2 load odd", 0, 1, 21'h12345, 0, 0, 2'd1, 0);
    check("R7 pc value", pc, 21'h12344);
    op("R7 latch kept", 0, 0, 0, 0, 0, 2'd1, 0);
    // R6 capture
    op("R6 low read", 0, 0, 0, 0, 1, 2'd0, 0);
    op("R6 mid captured", 0, 0, 0, 0, 0, 2'd1, 0);
    op("R6 top captured", 0, 0, 0, 0, 0, 2'd2, 0);
    // R8 priorities
    op("R8 write beats advance", 1, 0, 0, 1, 0, 2'd0, 8'h40);
    op("R8 load beats write", 1, 1, 21'h00800, 1, 0, 2'd0, 8'h10);
    // R9 write plus read: no capture
    op("R9 setup load", 0, 1, 21'h1ABCDE, 0, 0, 2'd0, 0);
    op("R9 mid write+read", 0, 0, 0, 1, 1, 2'd1, 8'h5A);
    op("R9 low write+read", 0, 0, 0, 1, 1, 2'd0, 8'h22);
    op("R9 mid kept", 0, 0, 0, 0, 0, 2'd1, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      op("R3 R5 R6 R7 R8 random", r[0] | r[1], (r[4:2] == 3'd0), PC_W'($urandom),
         (r[7:5] < 3'd2), (r[10:8] < 3'd2), r[12:11], r[20:13]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule